// File: doc/BRIEF.md
# Debug Access Address Range Decoder

This block sits between a debug or host access port and the memories behind it. The port issues byte transfers into a flat 32-bit address space. Each transfer is a start address, a byte count and a direction flag. For each transfer the block picks one of three targets and gives the local offset inside that target. The targets are a unified memory split into fixed-size segments, an instruction memory and a data memory.

A transfer can be refused for one of four reasons:
- its address falls in no region;
- it runs past the end of the instruction or data region;
- it spans two unified segments;
- it lands in a unified segment that is not populated.

A refused transfer is not fatal. It is answered as a zero-byte transfer with no target, and a two-bit error code tells the port why. A unified transfer whose end lies exactly on the next segment boundary is still accepted.

The memory arrays are outside this block. A bitmap input marks which unified segments exist.

Top module: `dbg_range_decoder`

## Requirements
- R1: An address with bits 31..24 all zero selects the unified target (code 1). The segment index is address bits 23..17 and the offset is bits 16..0.
- R2: An address from 0x01000000 to 0x0103FFFF selects the instruction target (code 2), with offset equal to address bits 17..0.
- R3: An address from 0x02000000 to 0x0200FFFF selects the data target (code 3), with offset equal to address bits 15..0.
- R4: Any address outside those three windows is refused with error code 3 (invalid or unmapped).
- R5: An instruction or data transfer is refused with error code 1 (out of range) when offset plus length exceeds the window size, 2^18 or 2^16 bytes.
- R6: A unified transfer is refused with error code 2 (cross segment) when the segment of address+length differs from the start segment. The one exception is an end equal to offset 0 of the very next segment, which is accepted.
- R7: A unified transfer that does not cross is refused with error code 3 when the seg_present bit of its start segment is 0. The cross-segment check takes priority over this one.
- R8: A refused transfer returns target 0 (none), granted length 0, offset 0 and segment 0. An accepted transfer returns its requested length. Error code 0 means accepted. The direction flag is echoed in both cases.
- R9: The response appears exactly one clock after the request, with rsp_valid high for that one cycle. All response fields, including the error code, hold until the next request.
- R10: After reset, rsp_valid, rsp_target, rsp_len, rsp_offset, rsp_segment, rsp_write and rsp_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request strobe |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 = write, 0 = read |
| seg_present | input | 2**SEG_W | One bit per unified segment, 1 = populated |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_target | output | 2 | 0 none, 1 unified, 2 instruction, 3 data |
| rsp_segment | output | SEG_W | Unified segment index |
| rsp_offset | output | max offset width | Byte offset inside the target |
| rsp_len | output | LEN_W | Granted length, 0 when refused |
| rsp_write | output | 1 | Echo of the direction flag |
| rsp_err | output | 2 | 0 ok, 1 out of range, 2 cross segment, 3 invalid/unmapped |

## Verification
Every result of this block is due one rising edge after its request: the decision is combinational and a single register bank holds it. The bench drives each request just after a falling edge. At the next falling edge it compares all response fields against a behavioural model that it advanced for that same request. In cycles without a request, the model keeps the previous fields and expects rsp_valid low. This is how the hold rule is checked on idle cycles as well.

// File: rtl/dbg_range_decoder.sv
module dbg_range_decoder #(
  parameter int          LEN_W      = 16,
  parameter int          SEG_W      = 7,
  parameter int          SEG_OFF_W  = 17,
  parameter int          IMEM_OFF_W = 18,
  parameter int          DMEM_OFF_W = 16,
  parameter logic [31:0] IMEM_BASE  = 32'h0100_0000,
  parameter logic [31:0] DMEM_BASE  = 32'h0200_0000,
  localparam int         NSEG       = 1 << SEG_W,
  localparam int         UNI_W      = SEG_W + SEG_OFF_W,
  localparam int         OFF_W      = (IMEM_OFF_W > SEG_OFF_W)
                                      ? ((IMEM_OFF_W > DMEM_OFF_W) ? IMEM_OFF_W : DMEM_OFF_W)
                                      : ((SEG_OFF_W > DMEM_OFF_W) ? SEG_OFF_W : DMEM_OFF_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_write,
  input  logic [NSEG-1:0]  seg_present,
  output logic             rsp_valid,
  output logic [1:0]       rsp_target,
  output logic [SEG_W-1:0] rsp_segment,
  output logic [OFF_W-1:0] rsp_offset,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_write,
  output logic [1:0]       rsp_err
);

  localparam logic [1:0] TGT_NONE = 2'd0, TGT_UNI = 2'd1, TGT_IMEM = 2'd2, TGT_DMEM = 2'd3;
  localparam logic [1:0] ERR_OK = 2'd0, ERR_RANGE = 2'd1, ERR_CROSS = 2'd2, ERR_BAD = 2'd3;

  wire in_uni  = (req_addr >> UNI_W) == 32'd0;
  wire in_imem = (req_addr >> IMEM_OFF_W) == (IMEM_BASE >> IMEM_OFF_W);
  wire in_dmem = (req_addr >> DMEM_OFF_W) == (DMEM_BASE >> DMEM_OFF_W);

  wire [32:0] len_x   = 33'(req_len);
  wire [32:0] u_end   = 33'(req_addr[UNI_W-1:0]) + len_x;
  wire [32:0] u_seg   = 33'(req_addr[UNI_W-1:SEG_OFF_W]);
  wire [32:0] u_eseg  = u_end >> SEG_OFF_W;
  wire        u_edge  = u_end[SEG_OFF_W-1:0] == '0;
  wire        u_cross = (u_eseg != u_seg) && !((u_eseg == u_seg + 33'd1) && u_edge);
  wire        u_map   = seg_present[req_addr[UNI_W-1:SEG_OFF_W]];
  wire        i_over  = (33'(req_addr[IMEM_OFF_W-1:0]) + len_x) > (33'd1 << IMEM_OFF_W);
  wire        d_over  = (33'(req_addr[DMEM_OFF_W-1:0]) + len_x) > (33'd1 << DMEM_OFF_W);

  logic [1:0]       n_tgt, n_err;
  logic [SEG_W-1:0] n_seg;
  logic [OFF_W-1:0] n_off;

  always_comb begin
    n_tgt = TGT_NONE;
    n_err = ERR_OK;
    n_seg = '0;
    n_off = '0;
    if (in_uni) begin
      if (u_cross)     n_err = ERR_CROSS;
      else if (!u_map) n_err = ERR_BAD;
      else begin
        n_tgt = TGT_UNI;
        n_seg = req_addr[UNI_W-1:SEG_OFF_W];
        n_off = OFF_W'(req_addr[SEG_OFF_W-1:0]);
      end
    end else if (in_imem) begin
      if (i_over) n_err = ERR_RANGE;
      else begin
        n_tgt = TGT_IMEM;
        n_off = OFF_W'(req_addr[IMEM_OFF_W-1:0]);
      end
    end else if (in_dmem) begin
      if (d_over) n_err = ERR_RANGE;
      else begin
        n_tgt = TGT_DMEM;
        n_off = OFF_W'(req_addr[DMEM_OFF_W-1:0]);
      end
    end else begin
      n_err = ERR_BAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_target  <= TGT_NONE;
      rsp_segment <= '0;
      rsp_offset  <= '0;
      rsp_len     <= '0;
      rsp_write   <= 1'b0;
      rsp_err     <= ERR_OK;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_target  <= n_tgt;
        rsp_segment <= n_seg;
        rsp_offset  <= n_off;
        rsp_len     <= (n_tgt == TGT_NONE) ? '0 : req_len;
        rsp_write   <= req_write;
        rsp_err     <= n_err;
      end
    end
  end

endmodule

// File: rtl/dbg_range_decoder_chk.sv
module dbg_range_decoder_chk #(
  parameter int LEN_W      = 16,
  parameter int SEG_W      = 7,
  parameter int OFF_W      = 18,
  parameter int DMEM_OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic [1:0]       rsp_target,
  input logic [SEG_W-1:0] rsp_segment,
  input logic [OFF_W-1:0] rsp_offset,
  input logic [LEN_W-1:0] rsp_len,
  input logic [1:0]       rsp_err
);

  a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r9_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_err) && $stable(rsp_target) && $stable(rsp_len));

  a_r8_reject_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> (rsp_target == 2'd0 && rsp_len == '0
                                        && rsp_offset == '0 && rsp_segment == '0));

  a_r8_accept_has_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err == 2'd0) |-> rsp_target != 2'd0);

  a_r5_data_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target == 2'd3) |->
      (33'(rsp_offset) + 33'(rsp_len)) <= (33'd1 << DMEM_OFF_W));

endmodule

bind dbg_range_decoder dbg_range_decoder_chk #(
  .LEN_W(LEN_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .DMEM_OFF_W(DMEM_OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_target(rsp_target), .rsp_segment(rsp_segment), .rsp_offset(rsp_offset),
  .rsp_len(rsp_len), .rsp_err(rsp_err)
);

// File: tb/dbg_range_decoder_test.sv
`timescale 1ns/1ps
module dbg_range_decoder_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [15:0]  req_len = '0;
  logic         req_write = 1'b0;
  logic [127:0] seg_present;
  logic         rsp_valid;
  logic [1:0]   rsp_target;
  logic [6:0]   rsp_segment;
  logic [17:0]  rsp_offset;
  logic [15:0]  rsp_len;
  logic         rsp_write;
  logic [1:0]   rsp_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  longint e_valid = 0, e_tgt = 0, e_seg = 0, e_off = 0, e_len = 0, e_wr = 0, e_err = 0;
  string  e_tag = "R10";

  always #2.5 clk = ~clk;

  dbg_range_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .seg_present(seg_present),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_segment(rsp_segment),
    .rsp_offset(rsp_offset), .rsp_len(rsp_len), .rsp_write(rsp_write), .rsp_err(rsp_err)
  );

  task automatic cmp(input string tag, input string fld, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, fld, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp(e_tag, "rsp_valid",   rsp_valid,   e_valid);
    cmp(e_tag, "rsp_target",  rsp_target,  e_tgt);
    cmp(e_tag, "rsp_segment", rsp_segment, e_seg);
    cmp(e_tag, "rsp_offset",  rsp_offset,  e_off);
    cmp(e_tag, "rsp_len",     rsp_len,     e_len);
    cmp(e_tag, "rsp_write",   rsp_write,   e_wr);
    cmp(e_tag, "rsp_err",     rsp_err,     e_err);
  endtask

  task automatic model(input longint a, input longint len, input bit wr);
    longint seg, eseg, eoff, off;
    e_valid = 1; e_tgt = 0; e_seg = 0; e_off = 0; e_len = 0; e_wr = wr; e_err = 0;
    if (a < 64'h0100_0000) begin
      seg  = a / 131072;
      eseg = (a + len) / 131072;
      eoff = (a + len) % 131072;
      if (eseg != seg && !(eseg == seg + 1 && eoff == 0)) e_err = 2;
      else if (!seg_present[seg]) e_err = 3;
      else begin e_tgt = 1; e_seg = seg; e_off = a % 131072; e_len = len; end
    end else if (a >= 64'h0100_0000 && a <= 64'h0103_FFFF) begin
      off = a - 64'h0100_0000;
      if (off + len > 262144) e_err = 1;
      else begin e_tgt = 2; e_off = off; e_len = len; end
    end else if (a >= 64'h0200_0000 && a <= 64'h0200_FFFF) begin
      off = a - 64'h0200_0000;
      if (off + len > 65536) e_err = 1;
      else begin e_tgt = 3; e_off = off; e_len = len; end
    end else begin
      e_err = 3;
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input int len, input bit wr, input string tag);
    @(negedge clk);
    compare_all();
    req_valid = v;
    req_addr  = a;
    req_len   = 16'(len);
    req_write = wr;
    if (v) model(longint'(a), longint'(len), wr);
    else   e_valid = 0;
    e_tag = tag;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 32'h0, 0, 1'b0, tag);
  endtask

  initial begin
    seg_present = '1;
    seg_present[5] = 1'b0;
    seg_present[6] = 1'b0;
    repeat (3) begin
      @(negedge clk);
      compare_all();
    end
    rst_n = 1'b1;

    step(1, 32'h0000_0100, 64, 1, "R1");
    step(1, 32'h0003_1234, 16, 0, "R1");
    idle("R9");
    step(1, 32'h00FF_FFFF, 1, 0, "R1");
    step(1, 32'h000A_0010, 8, 1, "R7");
    idle("R9");
    idle("R9");
    step(1, 32'h0001_FFF0, 32, 0, "R6");
    step(1, 32'h0001_FFF0, 16, 0, "R6");
    step(1, 32'h0009_FFFF, 2, 1, "R7");
    step(1, 32'h000B_FFFF, 2, 1, "R6");
    step(1, 32'h0004_0000, 0, 0, "R8");
    step(1, 32'h0100_0000, 4, 0, "R2");
    step(1, 32'h0103_FFFF, 1, 1, "R2");
    step(1, 32'h0103_FFFF, 2, 1, "R5");
    step(1, 32'h0104_0000, 1, 0, "R4");
    idle("R9");
    step(1, 32'h0102_2222, 100, 0, "R2");
    step(1, 32'h0200_0000, 8, 1, "R3");
    step(1, 32'h0200_FFF0, 16, 0, "R3");
    step(1, 32'h0200_FFF0, 17, 0, "R5");
    idle("R9");
    step(1, 32'h0201_0000, 1, 0, "R4");
    step(1, 32'h0300_0000, 4, 1, "R4");
    step(1, 32'hFFFF_FFFF, 1, 0, "R4");
    step(1, 32'h0100_0000, 65535, 0, "R2");
    step(1, 32'h0200_0001, 65535, 1, "R3");
    step(1, 32'h0200_0002, 65535, 1, "R5");
    idle("R9");
    idle("R9");
    for (int i = 0; i < 24; i++) begin
      step(1, 32'(i) * 32'h000A_3C41, (i * 977) % 40000, i[0], "R6");
      if (i % 5 == 0) idle("R9");
    end
    idle("R9");
    idle("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule